// File: doc/BRIEF.md
# Register File with Access-Error Responses

This block is a small 32-bit memory-mapped configuration space behind a single-transaction CPU request/response port. Three locations are held inside the block: a read/write storage word, a read-only constant, and a write-only storage word whose value drives a hardware output. Six further targets live outside the block: three single-word external registers and three 8-byte external memory windows. Accesses to them are forwarded over a request channel with one request strobe per target. The block then waits for the matching read or write acknowledge from that target.

Every CPU access completes with one acknowledge pulse carrying read data and an error flag. Two parameters decide when the flag is raised. The first covers accesses to addresses with nothing mapped. The second covers accesses in the wrong direction: a write to a read-only location or a read from a write-only location. Such accesses are never forwarded and have no effect, whatever the parameters say.

Byte address map (6-bit address): 0x00 local read/write, 0x04 local read-only, 0x08 local write-only, 0x0C / 0x10 / 0x14 external registers on channels 0 / 1 / 2, and 0x20 / 0x28 / 0x30 external windows on channels 3 / 4 / 5. All other addresses are unmapped. On each channel group, the read/write target comes first, then the read-only target, then the write-only target.

Top module: `cfg_space`

## Requirements
- R1: Reset is synchronous and active low (`rst_n` = 0 at a rising edge). It sets the word at 0x00 to 40 and the write-only word at 0x08 to 100, so `hw_wo_value` reads 100 after reset.
- R2: A write to 0x00 changes only the bits set in `cpu_biten`: new = (old & ~biten) | (wdata & biten). A read of 0x00 returns the current value with `cpu_err` = 0.
- R3: A read of 0x04 returns 80. A write to 0x04 leaves the value that later reads return unchanged.
- R4: A write to 0x08 updates `hw_wo_value` under the same bit-enable rule as R2. Reads of 0x08 return 0 and never change `hw_wo_value`.
- R5: An access to an external register (0x0C, 0x10, 0x14 on channels 0, 1, 2) raises bit `ch` of `ext_req` for exactly one cycle, and only that bit. With it the block presents `ext_wr` (1 = write), `ext_wdata` and `ext_biten`.
- R6: An access to an external window (0x20–0x27 on channel 3, 0x28–0x2F on channel 4, 0x30–0x37 on channel 5) behaves as in R5 and also drives `ext_addr` = `cpu_addr[2:0]`.
- R7: An access to an unmapped address (0x18–0x1F, 0x38–0x3F) is not forwarded and has no effect. It returns read data 0, with `cpu_err` = `ERR_BAD_ADDR`.
- R8: A write to a read-only location (0x04, channel 1, channel 4) or a read from a write-only location (0x08, channel 2, channel 5) is not forwarded and has no effect. It returns read data 0, with `cpu_err` = `ERR_BAD_DIR`.
- R9: An access in the legal direction to any mapped location completes with `cpu_err` = 0 under every parameter setting. A forwarded read returns the data that the acknowledging channel presents.
- R10: Local, unmapped and wrong-direction accesses give `cpu_ack` in the cycle after the request is sampled. A forwarded access gives `cpu_ack` in the cycle after the active channel's acknowledge of the matching kind is sampled. Acknowledges on any other channel are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Request strobe, sampled while no access is pending |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_biten | input | DATA_W | Per-bit write enable |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| cpu_err | output | 1 | Error flag, valid with `cpu_ack` |
| hw_wo_value | output | DATA_W | Current value of the write-only word at 0x08 |
| ext_req | output | NCH | One-cycle request strobe per external channel |
| ext_wr | output | 1 | Direction of the forwarded access |
| ext_addr | output | MEM_AW | Byte offset inside a window |
| ext_wdata | output | DATA_W | Forwarded write data |
| ext_biten | output | DATA_W | Forwarded bit enables |
| ext_rd_ack | input | NCH | Read acknowledge per channel |
| ext_rd_data | input | NCH*DATA_W | Read data per channel, channel k in bits k*DATA_W upward |
| ext_wr_ack | input | NCH | Write acknowledge per channel |

## Verification
A request is driven before rising edge E0. For every local, unmapped or wrong-direction access, `cpu_ack` is due just after E0. The bench's external responder sees the forwarded strobe at E1, may send a stray acknowledge on another channel after E2, and answers after E3, so a forwarded `cpu_ack` is due just after E4. The bench samples at each falling edge from the first one after E0 up to the one that is due. Any acknowledge before the due falling edge is flagged as early, and at the due falling edge the data and error flag are compared with a behavioural model of the map. The channel strobe, direction, window offset and write fields are checked at the first falling edge, while the one-cycle strobe is still up. Two instances run the same sequence, one with both error options set and one with both cleared.

// File: rtl/cfg_space_pkg.sv
// Package: shared constants, decode result type and the fixed address map of
// the configuration space. Assumes a byte-addressed map of at least 6 bits.
package cfg_space_pkg;

    localparam int NCH    = 6;                 // external channels
    localparam int CH_W   = $clog2(NCH);
    localparam int NLOC   = 3;                 // local words
    localparam int LOC_W  = 2;
    localparam int MEM_AW = 3;                 // window offset bits (8 bytes)

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_LOCAL = 2'd1,
        HIT_EXT   = 2'd2
    } hit_kind_e;

    typedef struct packed {
        hit_kind_e         kind;
        logic [LOC_W-1:0]  loc;
        logic [CH_W-1:0]   ch;
        logic              can_rd;
        logic              can_wr;
    } dec_t;

    // byte base of each external channel
    function automatic int unsigned ch_base(input int i);
        case (i)
            0:       return 32'h0C;
            1:       return 32'h10;
            2:       return 32'h14;
            3:       return 32'h20;
            4:       return 32'h28;
            default: return 32'h30;
        endcase
    endfunction

    // channels 3 and above are multi-byte windows
    function automatic bit ch_is_mem(input int i);
        return i >= 3;
    endfunction

    // direction rule within each group of three: rw, ro, wo
    function automatic bit slot_rd(input int i);
        return (i % 3) != 2;
    endfunction

    function automatic bit slot_wr(input int i);
        return (i % 3) != 1;
    endfunction

endpackage

// File: rtl/cfg_space_decode.sv
// Module: address decoder. Maps a byte address to local word, external
// channel or nothing, and reports which directions the target permits.
// Assumes ADDR_W >= 6 and non-overlapping map entries.
module cfg_space_decode
    import cfg_space_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic [NCH-1:0]  ch_hit;
    logic [NLOC-1:0] loc_hit;

    // one comparator per external channel, span chosen by channel type
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int SH = ch_is_mem(g) ? MEM_AW : 2;
        localparam logic [ADDR_W-1:0] BASE = ADDR_W'(ch_base(g));
        assign ch_hit[g] = (addr[ADDR_W-1:SH] == BASE[ADDR_W-1:SH]);
    end

    // one comparator per local word at byte 4*g
    for (genvar g = 0; g < NLOC; g++) begin : g_loc
        localparam logic [ADDR_W-1:0] LBASE = ADDR_W'(4 * g);
        assign loc_hit[g] = (addr[ADDR_W-1:2] == LBASE[ADDR_W-1:2]);
    end

    // fold the hit vectors into one decode record
    always_comb begin
        dec = '{kind: HIT_NONE, loc: '0, ch: '0, can_rd: 1'b0, can_wr: 1'b0};
        for (int i = 0; i < NLOC; i++) begin
            if (loc_hit[i]) begin
                dec.kind   = HIT_LOCAL;
                dec.loc    = LOC_W'(i);
                dec.can_rd = slot_rd(i);
                dec.can_wr = slot_wr(i);
            end
        end
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                dec.kind   = HIT_EXT;
                dec.ch     = CH_W'(i);
                dec.can_rd = slot_rd(i);
                dec.can_wr = slot_wr(i);
            end
        end
    end

endmodule

// File: rtl/cfg_space_locals.sv
// Module: local storage. Holds the read/write word and the write-only word,
// supplies the read-only constant, and applies per-bit write enables.
// Assumes write strobes are only raised for legal, decoded writes.
module cfg_space_locals
    import cfg_space_pkg::*;
#(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] RW_RST = DATA_W'(40),
    parameter logic [DATA_W-1:0] WO_RST = DATA_W'(100),
    parameter logic [DATA_W-1:0] RO_VAL = DATA_W'(80)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_rw,
    input  logic              we_wo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] biten,
    input  logic [LOC_W-1:0]  rsel,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] wo_value
);

    logic [DATA_W-1:0] rw_q;
    logic [DATA_W-1:0] wo_q;

    // storage update with bit-enable merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q <= RW_RST;
            wo_q <= WO_RST;
        end else begin
            if (we_rw) rw_q <= (rw_q & ~biten) | (wdata & biten);
            if (we_wo) wo_q <= (wo_q & ~biten) | (wdata & biten);
        end
    end

    // read mux; the write-only word never reaches software
    always_comb begin
        case (rsel)
            2'd0:    rdata = rw_q;
            2'd1:    rdata = RO_VAL;
            default: rdata = '0;
        endcase
    end

    assign wo_value = wo_q;

    // R2: bits outside the enable keep their earlier value
    assert_rw_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_rw |=> ((rw_q & ~$past(biten)) == ($past(rw_q) & ~$past(biten))));

endmodule

// File: rtl/cfg_space_ext_sel.sv
// Module: external response selector. Picks the acknowledge of the expected
// kind and the read data of the active channel; other channels are ignored.
// Assumes ch is below NCH.
module cfg_space_ext_sel
    import cfg_space_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [CH_W-1:0]       ch,
    input  logic                  is_wr,
    input  logic [NCH-1:0]        rd_ack,
    input  logic [NCH-1:0]        wr_ack,
    input  logic [NCH*DATA_W-1:0] rd_data_flat,
    output logic                  hit,
    output logic [DATA_W-1:0]     rdata
);

    logic [DATA_W-1:0] dat [NCH];

    // unpack the flat read data bus per channel
    for (genvar g = 0; g < NCH; g++) begin : g_unpack
        assign dat[g] = rd_data_flat[g*DATA_W +: DATA_W];
    end

    // select acknowledge and data of the active channel only
    always_comb begin
        hit   = is_wr ? wr_ack[ch] : rd_ack[ch];
        rdata = dat[ch];
    end

endmodule

// File: rtl/cfg_space.sv
// Module: configuration space top. Accepts one CPU access at a time, answers
// local, unmapped and wrong-direction accesses in one cycle, and forwards
// legal external accesses, waiting for the matching channel acknowledge.
// Assumes cpu_req is only raised while no earlier access is pending.
module cfg_space
    import cfg_space_pkg::*;
#(
    parameter int                DATA_W       = 32,
    parameter int                ADDR_W       = 6,
    parameter bit                ERR_BAD_ADDR = 1'b1,
    parameter bit                ERR_BAD_DIR  = 1'b1,
    parameter logic [DATA_W-1:0] RW_RST       = DATA_W'(40),
    parameter logic [DATA_W-1:0] WO_RST       = DATA_W'(100),
    parameter logic [DATA_W-1:0] RO_VAL       = DATA_W'(80)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_req,
    input  logic                  cpu_wr,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [DATA_W-1:0]     cpu_biten,
    output logic                  cpu_ack,
    output logic [DATA_W-1:0]     cpu_rdata,
    output logic                  cpu_err,
    output logic [DATA_W-1:0]     hw_wo_value,
    output logic [NCH-1:0]        ext_req,
    output logic                  ext_wr,
    output logic [MEM_AW-1:0]     ext_addr,
    output logic [DATA_W-1:0]     ext_wdata,
    output logic [DATA_W-1:0]     ext_biten,
    input  logic [NCH-1:0]        ext_rd_ack,
    input  logic [NCH*DATA_W-1:0] ext_rd_data,
    input  logic [NCH-1:0]        ext_wr_ack
);

    typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} state_e;

    state_e            st;
    dec_t              dec;
    logic              take;
    logic              legal;
    logic              we_rw;
    logic              we_wo;
    logic [DATA_W-1:0] loc_rdata;
    logic [CH_W-1:0]   act_ch;
    logic              sel_hit;
    logic [DATA_W-1:0] sel_rdata;

    cfg_space_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (cpu_addr),
        .dec  (dec)
    );

    // request qualification and local write strobes
    always_comb begin
        take  = (st == ST_IDLE) && cpu_req;
        legal = cpu_wr ? dec.can_wr : dec.can_rd;
        we_rw = take && cpu_wr && legal && (dec.kind == HIT_LOCAL) && (dec.loc == 2'd0);
        we_wo = take && cpu_wr && legal && (dec.kind == HIT_LOCAL) && (dec.loc == 2'd2);
    end

    cfg_space_locals #(
        .DATA_W (DATA_W),
        .RW_RST (RW_RST),
        .WO_RST (WO_RST),
        .RO_VAL (RO_VAL)
    ) u_loc (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_rw    (we_rw),
        .we_wo    (we_wo),
        .wdata    (cpu_wdata),
        .biten    (cpu_biten),
        .rsel     (dec.loc),
        .rdata    (loc_rdata),
        .wo_value (hw_wo_value)
    );

    cfg_space_ext_sel #(.DATA_W(DATA_W)) u_sel (
        .ch           (act_ch),
        .is_wr        (ext_wr),
        .rd_ack       (ext_rd_ack),
        .wr_ack       (ext_wr_ack),
        .rd_data_flat (ext_rd_data),
        .hit          (sel_hit),
        .rdata        (sel_rdata)
    );

    // transaction control: classify, respond or forward, then wait for ack
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cpu_ack   <= 1'b0;
            cpu_rdata <= '0;
            cpu_err   <= 1'b0;
            ext_req   <= '0;
            ext_wr    <= 1'b0;
            ext_addr  <= '0;
            ext_wdata <= '0;
            ext_biten <= '0;
            act_ch    <= '0;
        end else begin
            cpu_ack <= 1'b0;
            ext_req <= '0;
            case (st)
                ST_IDLE: begin
                    if (cpu_req) begin
                        if (dec.kind == HIT_NONE) begin
                            cpu_ack   <= 1'b1;
                            cpu_rdata <= '0;
                            cpu_err   <= ERR_BAD_ADDR;
                        end else if (!legal) begin
                            cpu_ack   <= 1'b1;
                            cpu_rdata <= '0;
                            cpu_err   <= ERR_BAD_DIR;
                        end else if (dec.kind == HIT_LOCAL) begin
                            cpu_ack   <= 1'b1;
                            cpu_rdata <= cpu_wr ? '0 : loc_rdata;
                            cpu_err   <= 1'b0;
                        end else begin
                            ext_req   <= NCH'(1) << dec.ch;
                            act_ch    <= dec.ch;
                            ext_wr    <= cpu_wr;
                            ext_addr  <= cpu_addr[MEM_AW-1:0];
                            ext_wdata <= cpu_wdata;
                            ext_biten <= cpu_biten;
                            st        <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (sel_hit) begin
                        cpu_ack   <= 1'b1;
                        cpu_rdata <= ext_wr ? '0 : sel_rdata;
                        cpu_err   <= 1'b0;
                        st        <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R5: at most one channel strobed at a time
    assert_ext_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_req));

    // R5: a channel strobe lasts one cycle
    assert_ext_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req != '0) |=> (ext_req == '0));

    // R10: an accepted request either completes or is forwarded next cycle
    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cpu_ack || (ext_req != '0)));

    // R9: a matching external acknowledge completes without error
    assert_ext_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WAIT) && sel_hit) |=> (cpu_ack && !cpu_err));

    // R7: an unmapped access answers with zero data and the configured flag
    assert_bad_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (dec.kind == HIT_NONE)) |=>
            (cpu_ack && (cpu_err == ERR_BAD_ADDR) && (cpu_rdata == '0)));

    // R4: reads never disturb the write-only word
    assert_read_keeps_wo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cpu_wr) |=> $stable(hw_wo_value));

endmodule

// File: tb/sim_cfg_space.sv
`timescale 1ns/100ps

// Bench responder: models the six external targets with their own storage,
// answering a strobe two edges later and optionally sending a stray
// acknowledge on a neighbouring channel in between.
module sim_ext_resp (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stray,
    input  logic [5:0]   req,
    input  logic         wr,
    input  logic [2:0]   addr,
    input  logic [31:0]  wdata,
    input  logic [31:0]  biten,
    output logic [5:0]   rd_ack,
    output logic [5:0]   wr_ack,
    output logic [191:0] rd_data
);
    logic [31:0] regs [3];
    logic [31:0] mem  [3][2];
    logic        p1, p2, pwr, pword;
    int          pch;
    logic [31:0] pwd, pbe;

    function automatic int idx_of(input logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return i;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                regs[i]   <= 32'hA0 + i;
                mem[i][0] <= 32'hB0 + 2*i;
                mem[i][1] <= 32'hB1 + 2*i;
            end
            p1 <= 1'b0; p2 <= 1'b0;
            rd_ack <= '0; wr_ack <= '0; rd_data <= '0;
            pch <= 0; pwr <= 1'b0; pword <= 1'b0; pwd <= '0; pbe <= '0;
        end else begin
            rd_ack <= '0;
            wr_ack <= '0;
            p2 <= p1;
            p1 <= 1'b0;
            if (req != '0) begin
                p1 <= 1'b1; pch <= idx_of(req); pwr <= wr;
                pword <= addr[2]; pwd <= wdata; pbe <= biten;
            end
            if (p1 && stray) begin
                rd_ack[(pch + 1) % 6] <= 1'b1;
                wr_ack[(pch + 1) % 6] <= 1'b1;
                rd_data <= {6{32'hDEAD_BEEF}};
            end
            if (p2) begin
                if (pwr) begin
                    wr_ack[pch] <= 1'b1;
                    if (pch < 3) regs[pch] <= (regs[pch] & ~pbe) | (pwd & pbe);
                    else mem[pch-3][pword] <= (mem[pch-3][pword] & ~pbe) | (pwd & pbe);
                end else begin
                    rd_ack[pch] <= 1'b1;
                    rd_data[pch*32 +: 32] <= (pch < 3) ? regs[pch] : mem[pch-3][pword];
                end
            end
        end
    end
endmodule

// Bench: two instances (error options on / off) driven with one sequence and
// compared with a behavioural map model at every falling edge.
module sim_cfg_space;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic         cpu_req  [2];
    logic         cpu_wr   [2];
    logic [5:0]   cpu_addr [2];
    logic [31:0]  cpu_wdata[2];
    logic [31:0]  cpu_biten[2];
    logic         cpu_ack  [2];
    logic [31:0]  cpu_rdata[2];
    logic         cpu_err  [2];
    logic [31:0]  hw_wo    [2];
    logic [5:0]   ext_req  [2];
    logic         ext_wr   [2];
    logic [2:0]   ext_addr [2];
    logic [31:0]  ext_wdata[2];
    logic [31:0]  ext_biten[2];
    logic [5:0]   ext_rd_ack[2];
    logic [5:0]   ext_wr_ack[2];
    logic [191:0] ext_rd_data[2];
    logic         stray    [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit opt_addr [2] = '{1'b1, 1'b0};
    bit opt_dir  [2] = '{1'b1, 1'b0};

    logic [31:0] m_rw  [2];
    logic [31:0] m_wo  [2];
    logic [31:0] m_reg [2][3];
    logic [31:0] m_mem [2][3][2];

    cfg_space #(.ERR_BAD_ADDR(1'b1), .ERR_BAD_DIR(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_wr(cpu_wr[0]),
        .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_biten(cpu_biten[0]),
        .cpu_ack(cpu_ack[0]), .cpu_rdata(cpu_rdata[0]), .cpu_err(cpu_err[0]),
        .hw_wo_value(hw_wo[0]), .ext_req(ext_req[0]), .ext_wr(ext_wr[0]),
        .ext_addr(ext_addr[0]), .ext_wdata(ext_wdata[0]), .ext_biten(ext_biten[0]),
        .ext_rd_ack(ext_rd_ack[0]), .ext_rd_data(ext_rd_data[0]), .ext_wr_ack(ext_wr_ack[0]));

    cfg_space #(.ERR_BAD_ADDR(1'b0), .ERR_BAD_DIR(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_wr(cpu_wr[1]),
        .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_biten(cpu_biten[1]),
        .cpu_ack(cpu_ack[1]), .cpu_rdata(cpu_rdata[1]), .cpu_err(cpu_err[1]),
        .hw_wo_value(hw_wo[1]), .ext_req(ext_req[1]), .ext_wr(ext_wr[1]),
        .ext_addr(ext_addr[1]), .ext_wdata(ext_wdata[1]), .ext_biten(ext_biten[1]),
        .ext_rd_ack(ext_rd_ack[1]), .ext_rd_data(ext_rd_data[1]), .ext_wr_ack(ext_wr_ack[1]));

    sim_ext_resp r0 (
        .clk(clk), .rst_n(rst_n), .stray(stray[0]), .req(ext_req[0]), .wr(ext_wr[0]),
        .addr(ext_addr[0]), .wdata(ext_wdata[0]), .biten(ext_biten[0]),
        .rd_ack(ext_rd_ack[0]), .wr_ack(ext_wr_ack[0]), .rd_data(ext_rd_data[0]));

    sim_ext_resp r1 (
        .clk(clk), .rst_n(rst_n), .stray(stray[1]), .req(ext_req[1]), .wr(ext_wr[1]),
        .addr(ext_addr[1]), .wdata(ext_wdata[1]), .biten(ext_biten[1]),
        .rd_ack(ext_rd_ack[1]), .wr_ack(ext_wr_ack[1]), .rd_data(ext_rd_data[1]));

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] w,
                                          input logic [31:0] b);
        return (o & ~b) | (w & b);
    endfunction

    function automatic logic [31:0] resp_val(input int d, input int ch, input bit w);
        if (d == 0) return (ch < 3) ? r0.regs[ch] : r0.mem[ch-3][w];
        return (ch < 3) ? r1.regs[ch] : r1.mem[ch-3][w];
    endfunction

    // one access on instance d, checked against the map model
    task automatic access(input int d, input bit wr, input logic [5:0] a,
                          input logic [31:0] wd, input logic [31:0] be,
                          input bit stray_on, input string rq);
        int kind = 0;
        int idx = 0;
        bit crd, cwr, legal, fwd, early;
        logic [31:0] exp_d;
        bit exp_e;
        int due;
        if (a[5:2] <= 4'd2) begin kind = 1; idx = int'(a[5:2]); end
        else if (a[5:2] <= 4'd5) begin kind = 2; idx = int'(a[5:2]) - 3; end
        else if (a[5:3] >= 3'd4 && a[5:3] <= 3'd6) begin kind = 2; idx = int'(a[5:3]) - 1; end
        crd = (idx % 3) != 2;
        cwr = (idx % 3) != 1;
        legal = wr ? cwr : crd;
        fwd = 1'b0; exp_d = '0; exp_e = 1'b0; due = 1;
        if (kind == 0) exp_e = opt_addr[d];
        else if (!legal) exp_e = opt_dir[d];
        else if (kind == 1) begin
            if (wr) begin
                if (idx == 0) m_rw[d] = merge(m_rw[d], wd, be);
                else m_wo[d] = merge(m_wo[d], wd, be);
            end else exp_d = (idx == 0) ? m_rw[d] : 32'd80;
        end else begin
            fwd = 1'b1; due = 5;
            if (wr) begin
                if (idx < 3) m_reg[d][idx] = merge(m_reg[d][idx], wd, be);
                else m_mem[d][idx-3][a[2]] = merge(m_mem[d][idx-3][a[2]], wd, be);
            end else exp_d = (idx < 3) ? m_reg[d][idx] : m_mem[d][idx-3][a[2]];
        end
        @(negedge clk);
        cpu_req[d] = 1'b1; cpu_wr[d] = wr; cpu_addr[d] = a;
        cpu_wdata[d] = wd; cpu_biten[d] = be; stray[d] = stray_on;
        early = 1'b0;
        for (int k = 1; k <= due; k++) begin
            @(negedge clk);
            if (k == 1) begin
                cpu_req[d] = 1'b0;
                if (fwd) begin
                    chk(ext_req[d] == (6'd1 << idx), rq, "ext_req strobe", 32'(ext_req[d]), 32'(6'd1 << idx));
                    chk(ext_wr[d] == wr, rq, "ext_wr", 32'(ext_wr[d]), 32'(wr));
                    if (idx >= 3) chk(ext_addr[d] == a[2:0], "R6", "ext_addr", 32'(ext_addr[d]), 32'(a[2:0]));
                    if (wr) begin
                        chk(ext_wdata[d] == wd, rq, "ext_wdata", ext_wdata[d], wd);
                        chk(ext_biten[d] == be, rq, "ext_biten", ext_biten[d], be);
                    end
                end else begin
                    chk(ext_req[d] == 6'd0, rq, "no forward", 32'(ext_req[d]), 32'd0);
                end
            end
            if (k < due && cpu_ack[d]) early = 1'b1;
            if (k == due) begin
                chk(!early, "R10", "early ack", 32'(early), 32'd0);
                chk(cpu_ack[d] == 1'b1, "R10", "ack at due cycle", 32'(cpu_ack[d]), 32'd1);
                chk(cpu_err[d] == exp_e, rq, $sformatf("err @%h", a), 32'(cpu_err[d]), 32'(exp_e));
                if (!wr) chk(cpu_rdata[d] == exp_d, rq, $sformatf("rdata @%h", a), cpu_rdata[d], exp_d);
            end
        end
        stray[d] = 1'b0;
        chk(hw_wo[d] == m_wo[d], "R4", "hw_wo_value", hw_wo[d], m_wo[d]);
        if (fwd && wr) begin
            repeat (1) @(negedge clk);
            chk(resp_val(d, idx, a[2]) == ((idx < 3) ? m_reg[d][idx] : m_mem[d][idx-3][a[2]]),
                rq, "target storage", resp_val(d, idx, a[2]),
                (idx < 3) ? m_reg[d][idx] : m_mem[d][idx-3][a[2]]);
        end
    endtask

    task automatic run_all(input int d);
        // R1: reset values
        chk(hw_wo[d] == 32'd100, "R1", "hw_wo after reset", hw_wo[d], 32'd100);
        access(d, 1'b0, 6'h00, 0, 0, 1'b0, "R1");
        // R2: storage word with bit enables
        access(d, 1'b1, 6'h00, 32'd61, 32'hFFFF_FFFF, 1'b0, "R2");
        access(d, 1'b0, 6'h00, 0, 0, 1'b0, "R2");
        access(d, 1'b1, 6'h00, 32'hFFFF_FFFF, 32'h0000_FF00, 1'b0, "R2");
        access(d, 1'b0, 6'h00, 0, 0, 1'b0, "R2");
        // R3 / R8: read-only constant
        access(d, 1'b0, 6'h04, 0, 0, 1'b0, "R3");
        access(d, 1'b1, 6'h04, 32'd81, 32'hFFFF_FFFF, 1'b0, "R8");
        access(d, 1'b0, 6'h04, 0, 0, 1'b0, "R3");
        // R4 / R8: write-only word
        access(d, 1'b0, 6'h08, 0, 0, 1'b0, "R8");
        access(d, 1'b1, 6'h08, 32'd101, 32'hFFFF_FFFF, 1'b0, "R4");
        access(d, 1'b1, 6'h08, 32'h0000_5A00, 32'h0000_FF00, 1'b0, "R4");
        access(d, 1'b0, 6'h08, 0, 0, 1'b0, "R8");
        // R5 / R9 / R10: external registers, stray acks on some
        access(d, 1'b0, 6'h0C, 0, 0, 1'b0, "R9");
        access(d, 1'b1, 6'h0C, 32'h8D, 32'hFFFF_FFFF, 1'b1, "R5");
        access(d, 1'b0, 6'h0C, 0, 0, 1'b1, "R10");
        access(d, 1'b0, 6'h10, 0, 0, 1'b0, "R5");
        access(d, 1'b1, 6'h10, 32'hB5, 32'hFFFF_FFFF, 1'b0, "R8");
        access(d, 1'b0, 6'h10, 0, 0, 1'b0, "R5");
        access(d, 1'b0, 6'h14, 0, 0, 1'b0, "R8");
        access(d, 1'b1, 6'h14, 32'hC9, 32'h0000_00FF, 1'b1, "R5");
        // R6: external windows, both words
        access(d, 1'b0, 6'h20, 0, 0, 1'b0, "R6");
        access(d, 1'b1, 6'h24, 32'h1234_5678, 32'hFFFF_0000, 1'b0, "R6");
        access(d, 1'b0, 6'h24, 0, 0, 1'b1, "R6");
        access(d, 1'b0, 6'h2C, 0, 0, 1'b0, "R6");
        access(d, 1'b1, 6'h28, 32'hB5, 32'hFFFF_FFFF, 1'b0, "R8");
        access(d, 1'b0, 6'h28, 0, 0, 1'b0, "R6");
        access(d, 1'b0, 6'h30, 0, 0, 1'b0, "R8");
        access(d, 1'b1, 6'h34, 32'hC9, 32'hFFFF_FFFF, 1'b0, "R6");
        // R7: unmapped holes, then confirm no side effect
        access(d, 1'b0, 6'h18, 0, 0, 1'b0, "R7");
        access(d, 1'b1, 6'h18, 32'h8C, 32'hFFFF_FFFF, 1'b0, "R7");
        access(d, 1'b1, 6'h1C, 32'h0, 32'hFFFF_FFFF, 1'b0, "R7");
        access(d, 1'b0, 6'h3C, 0, 0, 1'b0, "R7");
        access(d, 1'b1, 6'h38, 32'h0, 32'hFFFF_FFFF, 1'b0, "R7");
        access(d, 1'b0, 6'h00, 0, 0, 1'b0, "R7");
    endtask

    initial begin
        for (int d = 0; d < 2; d++) begin
            cpu_req[d] = 1'b0; cpu_wr[d] = 1'b0; cpu_addr[d] = '0;
            cpu_wdata[d] = '0; cpu_biten[d] = '0; stray[d] = 1'b0;
            m_rw[d] = 32'd40; m_wo[d] = 32'd100;
            for (int i = 0; i < 3; i++) begin
                m_reg[d][i]    = 32'hA0 + i;
                m_mem[d][i][0] = 32'hB0 + 2*i;
                m_mem[d][i][1] = 32'hB1 + 2*i;
            end
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(cpu_ack[d] == 1'b0, "R1", "ack idle after reset", 32'(cpu_ack[d]), 32'd0);
            chk(ext_req[d] == 6'd0, "R1", "no strobe after reset", 32'(ext_req[d]), 32'd0);
        end
        run_all(0);
        run_all(1);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule